// File: doc/BRIEF.md
# Ethernet Receive Destination Address Filter

This block decides whether an incoming Ethernet frame is kept, using only the 48-bit destination address at the start of the frame. The receive path feeds the address in one octet per strobe, and marks the first octet with a start-of-frame flag. Once the sixth octet has arrived, the block produces one registered accept or reject result together with a one-cycle valid pulse. Checking the frame body and every later stage of the MAC belong to other blocks.

The block has a small write port that loads its settings: the station address, a 64-entry multicast hash table and two mode bits (promiscuous, broadcast reject). Frames follow this priority. Promiscuous mode accepts every frame. The all-ones broadcast address is accepted unless broadcast reject is set. Any other address with the group bit set is looked up in the hash table. Every remaining frame must match the station address exactly.

Top module: `rx_addr_filter`

## Requirements
- R1: While reset is high, and in the first cycle after it falls, `dec_valid` is 0. Reset clears the station address, both hash words and both mode bits.
- R2: Write select 0 loads octets 2,3,4,5 of the station address from `wr_data[31:24]`, `[23:16]`, `[15:8]` and `[7:0]`. Write select 1 loads octet 0 from `wr_data[15:8]` and octet 1 from `wr_data[7:0]`. Octet 0 is the first octet on the wire. A frame whose six octets equal the station address is accepted.
- R3: A frame whose first octet has bit 0 clear, and which does not equal the station address in all six octets, is rejected.
- R4: A frame addressed to FF:FF:FF:FF:FF:FF is accepted when the broadcast-reject bit (`wr_data[1]` at select 4) is 0 and rejected when it is 1.
- R5: When the promiscuous bit (`wr_data[0]` at select 4) is 1, every frame is accepted.
- R6: For a frame with bit 0 of its first octet set that is not broadcast, the hash index is bits 31:26 of a CRC-32. The CRC is computed over the six octets with the reflected polynomial 0xEDB88320, starts from all ones, takes each octet LSB first and is not inverted. Index bit 5 chooses the hash word: select 2 (lower) for 0, select 3 (upper) for 1. Index bits 4:0 choose the bit in that word. The frame is accepted exactly when that bit is 1.
- R7: With both hash words all ones every multicast frame is accepted; with both all zeros every multicast frame is rejected.
- R8: `dec_valid` is high for exactly one cycle, namely the cycle after the edge that samples the sixth octet. Idle cycles between octets do not change this.
- R9: An octet with `octet_sof` set always starts a new address, even if an earlier one is only partly received. Octets that arrive with no frame open (none since reset, or after the sixth) produce no decision.
- R10: A register write takes effect for decisions made at later edges. A decision made at the same edge as a write uses the old settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Settings write strobe |
| wr_sel | input | 3 | Settings word select: 0 addr low, 1 addr high, 2 hash low, 3 hash high, 4 mode |
| wr_data | input | 32 | Settings write data |
| octet_vld | input | 1 | Destination octet valid |
| octet_sof | input | 1 | Marks the first octet of a frame (qualified by `octet_vld`) |
| octet | input | 8 | Destination address octet |
| dec_valid | output | 1 | One-cycle decision strobe |
| dec_accept | output | 1 | Decision: 1 accept, 0 reject (meaningful with `dec_valid`) |

## Verification
The only timed result is the decision. It is due one edge after the sixth octet is sampled, and it is never due in any other cycle. A settings write counts at the edge after it is presented. A model in the bench updates at each rising edge from the inputs it sees there, so it predicts the value the registered outputs will hold after that edge. The bench compares that prediction with the outputs at the following falling edge on every cycle. Frames are sent back to back, with idle gaps between octets, restarted partway through, and followed by stray octets, so a decision that comes early, late or spuriously is caught in the exact cycle it happens.

// File: rtl/rx_addr_filter_pkg.sv
package rx_addr_filter_pkg;
  localparam int unsigned OCTET_W  = 8;
  localparam int unsigned CFG_W    = 32;
  localparam int unsigned CRC_W    = 32;
  localparam logic [CRC_W-1:0] CRC_POLY = 32'hEDB88320;

  typedef enum logic [2:0] {
    SEL_ADDR_LO = 3'd0,
    SEL_ADDR_HI = 3'd1,
    SEL_HASH_LO = 3'd2,
    SEL_HASH_HI = 3'd3,
    SEL_MODE    = 3'd4
  } cfg_sel_e;
endpackage

// File: rtl/rx_addr_filter_cfg.sv
module rx_addr_filter_cfg
  import rx_addr_filter_pkg::*;
#(
  parameter int unsigned ADDR_OCTETS = 6,
  parameter int unsigned HASH_BITS   = 64,
  localparam int unsigned STN_W      = ADDR_OCTETS * OCTET_W
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic [2:0]           wr_sel,
  input  logic [CFG_W-1:0]     wr_data,
  output logic [STN_W-1:0]     station,   // octet k at [k*8 +: 8]
  output logic [HASH_BITS-1:0] hash_tbl,
  output logic                 promisc,
  output logic                 bcast_rej
);
  localparam int unsigned LO_OCTETS = 4;
  localparam int unsigned HI_OCTETS = ADDR_OCTETS - LO_OCTETS;
  localparam int unsigned HWORD     = HASH_BITS / 2;

  logic [OCTET_W-1:0] stn_q [ADDR_OCTETS];

  // low word: octets HI_OCTETS.. in descending bit order
  for (genvar j = 0; j < LO_OCTETS; j++) begin : g_lo
    always_ff @(posedge clk) begin
      if (rst)
        stn_q[HI_OCTETS+j] <= '0;
      else if (wr_en && wr_sel == SEL_ADDR_LO)
        stn_q[HI_OCTETS+j] <= wr_data[(LO_OCTETS-1-j)*OCTET_W +: OCTET_W];
    end
  end

  for (genvar j = 0; j < HI_OCTETS; j++) begin : g_hi
    always_ff @(posedge clk) begin
      if (rst)
        stn_q[j] <= '0;
      else if (wr_en && wr_sel == SEL_ADDR_HI)
        stn_q[j] <= wr_data[(HI_OCTETS-1-j)*OCTET_W +: OCTET_W];
    end
  end

  for (genvar k = 0; k < ADDR_OCTETS; k++) begin : g_pack
    assign station[k*OCTET_W +: OCTET_W] = stn_q[k];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hash_tbl  <= '0;
      promisc   <= 1'b0;
      bcast_rej <= 1'b0;
    end else if (wr_en) begin
      case (cfg_sel_e'(wr_sel))
        SEL_HASH_LO: hash_tbl[HWORD-1:0]         <= wr_data[HWORD-1:0];
        SEL_HASH_HI: hash_tbl[HASH_BITS-1:HWORD] <= wr_data[HWORD-1:0];
        SEL_MODE: begin
          promisc   <= wr_data[0];
          bcast_rej <= wr_data[1];
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/rx_addr_filter_crc.sv
module rx_addr_filter_crc
  import rx_addr_filter_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic               step,
  input  logic [OCTET_W-1:0] octet,
  output logic [CRC_W-1:0]   crc_next
);
  logic [CRC_W-1:0] crc_q;
  logic [CRC_W-1:0] chain [OCTET_W+1];

  assign chain[0] = (start ? {CRC_W{1'b1}} : crc_q) ^ {{(CRC_W-OCTET_W){1'b0}}, octet};

  for (genvar b = 0; b < OCTET_W; b++) begin : g_bit
    assign chain[b+1] = chain[b][0] ? ((chain[b] >> 1) ^ CRC_POLY) : (chain[b] >> 1);
  end

  assign crc_next = chain[OCTET_W];

  always_ff @(posedge clk) begin
    if (rst)       crc_q <= {CRC_W{1'b1}};
    else if (step) crc_q <= crc_next;
  end
endmodule

// File: rtl/rx_addr_filter_track.sv
module rx_addr_filter_track
  import rx_addr_filter_pkg::*;
#(
  parameter int unsigned ADDR_OCTETS = 6,
  localparam int unsigned STN_W      = ADDR_OCTETS * OCTET_W,
  localparam int unsigned POS_W      = $clog2(ADDR_OCTETS)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               octet_vld,
  input  logic               octet_sof,
  input  logic [OCTET_W-1:0] octet,
  input  logic [STN_W-1:0]   station,
  output logic               take,
  output logic               last,
  output logic               eq_next,
  output logic               bc_next,
  output logic               mc_next
);
  logic             active_q;
  logic [POS_W-1:0] pos_q;
  logic [POS_W-1:0] cur_pos;
  logic             eq_q, bc_q, mc_q;

  assign take    = octet_vld && (octet_sof || active_q);
  assign cur_pos = octet_sof ? '0 : pos_q;
  assign last    = take && (cur_pos == POS_W'(ADDR_OCTETS-1));
  assign eq_next = (octet_sof || eq_q) && (octet == station[cur_pos*OCTET_W +: OCTET_W]);
  assign bc_next = (octet_sof || bc_q) && (octet == {OCTET_W{1'b1}});
  assign mc_next = octet_sof ? octet[0] : mc_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= 1'b0;
      pos_q    <= '0;
      eq_q     <= 1'b0;
      bc_q     <= 1'b0;
      mc_q     <= 1'b0;
    end else if (take) begin
      active_q <= !last;
      pos_q    <= last ? '0 : cur_pos + 1'b1;
      eq_q     <= eq_next;
      bc_q     <= bc_next;
      mc_q     <= mc_next;
    end
  end

  p_pos_range_r9: assert property (@(posedge clk) disable iff (rst)
    active_q |-> (pos_q != '0 && pos_q < POS_W'(ADDR_OCTETS)));

  p_restart_r9: assert property (@(posedge clk) disable iff (rst)
    (octet_vld && octet_sof) |=> (active_q && pos_q == POS_W'(1)));
endmodule

// File: rtl/rx_addr_filter.sv
module rx_addr_filter
  import rx_addr_filter_pkg::*;
#(
  parameter int unsigned ADDR_OCTETS = 6,
  parameter int unsigned HASH_IDX_W  = 6,
  localparam int unsigned HASH_BITS  = 1 << HASH_IDX_W,
  localparam int unsigned STN_W      = ADDR_OCTETS * OCTET_W
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        wr_en,
  input  logic [2:0]  wr_sel,
  input  logic [31:0] wr_data,
  input  logic        octet_vld,
  input  logic        octet_sof,
  input  logic [7:0]  octet,
  output logic        dec_valid,
  output logic        dec_accept
);
  logic [STN_W-1:0]      station;
  logic [HASH_BITS-1:0]  hash_tbl;
  logic                  promisc, bcast_rej;
  logic                  take, last, eq_next, bc_next, mc_next;
  logic [CRC_W-1:0]      crc_next;
  logic [HASH_IDX_W-1:0] hidx;
  logic                  accept_d;

  rx_addr_filter_cfg #(.ADDR_OCTETS(ADDR_OCTETS), .HASH_BITS(HASH_BITS)) u_cfg (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .station(station), .hash_tbl(hash_tbl), .promisc(promisc), .bcast_rej(bcast_rej)
  );

  rx_addr_filter_track #(.ADDR_OCTETS(ADDR_OCTETS)) u_track (
    .clk(clk), .rst(rst), .octet_vld(octet_vld), .octet_sof(octet_sof), .octet(octet),
    .station(station), .take(take), .last(last),
    .eq_next(eq_next), .bc_next(bc_next), .mc_next(mc_next)
  );

  rx_addr_filter_crc u_crc (
    .clk(clk), .rst(rst), .start(octet_sof), .step(take), .octet(octet),
    .crc_next(crc_next)
  );

  assign hidx = crc_next[CRC_W-1 -: HASH_IDX_W];

  always_comb begin
    if (promisc)      accept_d = 1'b1;
    else if (bc_next) accept_d = !bcast_rej;
    else if (mc_next) accept_d = hash_tbl[hidx];
    else              accept_d = eq_next;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dec_valid  <= 1'b0;
      dec_accept <= 1'b0;
    end else begin
      dec_valid  <= last;
      dec_accept <= last && accept_d;
    end
  end

  p_single_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    dec_valid |=> !dec_valid);

  p_promisc_accept_r5: assert property (@(posedge clk) disable iff (rst)
    (last && promisc) |=> (dec_valid && dec_accept));

  p_bcast_reject_r4: assert property (@(posedge clk) disable iff (rst)
    (last && bc_next && bcast_rej && !promisc) |=> (dec_valid && !dec_accept));

  p_accept_needs_valid_r8: assert property (@(posedge clk) disable iff (rst)
    dec_accept |-> dec_valid);
endmodule

// File: tb/rx_addr_filter_tb_top.sv
module rx_addr_filter_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_sel = '0;
  logic [31:0] wr_data = '0;
  logic        octet_vld = 1'b0;
  logic        octet_sof = 1'b0;
  logic [7:0]  octet = '0;
  logic        dec_valid, dec_accept;

  int    n_cmp = 0;
  int    n_bad = 0;
  bit    done  = 1'b0;
  string cur_req = "R1";

  rx_addr_filter dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .octet_vld(octet_vld), .octet_sof(octet_sof), .octet(octet),
    .dec_valid(dec_valid), .dec_accept(dec_accept)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // ---------------- reference model ----------------
  logic [7:0]  m_stn [6];
  logic [63:0] m_hash;
  bit          m_prom, m_rej, m_active;
  logic [7:0]  fq[$];
  bit          exp_v = 1'b0, exp_a = 1'b0;

  function automatic logic [31:0] ref_crc(input logic [7:0] a [6]);
    logic [31:0] c = 32'hFFFFFFFF;
    for (int i = 0; i < 6; i++) begin
      c ^= {24'h0, a[i]};
      for (int b = 0; b < 8; b++) c = c[0] ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
    end
    return c;
  endfunction

  function automatic bit ref_decide();
    logic [7:0] a [6];
    bit bc = 1'b1, eq = 1'b1;
    int idx;
    for (int i = 0; i < 6; i++) begin
      a[i] = fq[i];
      if (a[i] != 8'hFF) bc = 1'b0;
      if (a[i] != m_stn[i]) eq = 1'b0;
    end
    if (m_prom) return 1'b1;
    if (bc) return !m_rej;
    if (a[0][0]) begin
      idx = int'(ref_crc(a) >> 26);
      return m_hash[idx];
    end
    return eq;
  endfunction

  always @(posedge clk) begin
    bit nv, na;
    nv = 1'b0; na = 1'b0;
    if (rst) begin
      for (int i = 0; i < 6; i++) m_stn[i] = 8'h00;
      m_hash = '0; m_prom = 1'b0; m_rej = 1'b0; m_active = 1'b0;
      fq.delete();
    end else begin
      if (octet_vld) begin
        if (octet_sof) begin
          fq.delete(); fq.push_back(octet); m_active = 1'b1;
        end else if (m_active) begin
          fq.push_back(octet);
        end
        if (m_active && fq.size() == 6) begin
          nv = 1'b1; na = ref_decide(); m_active = 1'b0;
        end
      end
      if (wr_en) begin
        case (wr_sel)
          3'd0: begin m_stn[2] = wr_data[31:24]; m_stn[3] = wr_data[23:16];
                      m_stn[4] = wr_data[15:8];  m_stn[5] = wr_data[7:0]; end
          3'd1: begin m_stn[0] = wr_data[15:8];  m_stn[1] = wr_data[7:0]; end
          3'd2: m_hash[31:0]  = wr_data;
          3'd3: m_hash[63:32] = wr_data;
          3'd4: begin m_prom = wr_data[0]; m_rej = wr_data[1]; end
          default: ;
        endcase
      end
    end
    exp_v = nv; exp_a = na;
  end

  // every-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (!done) begin
      n_cmp++;
      if (dec_valid !== exp_v || (exp_v && dec_accept !== exp_a)) begin
        n_bad++;
        $display("FAIL %s t=%0t valid/accept actual=%b/%b expected=%b/%b",
                 cur_req, $time, dec_valid, dec_accept, exp_v, exp_a);
      end
    end
  end

  // ---------------- stimulus ----------------
  task automatic drive(input bit v, input bit s, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b0; octet_vld = v; octet_sof = s; octet = d;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drive(1'b0, 1'b0, 8'h00);
  endtask

  task automatic wr(input logic [2:0] sel, input logic [31:0] d);
    @(negedge clk);
    octet_vld = 1'b0; octet_sof = 1'b0;
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
  endtask

  task automatic send(input logic [47:0] a, input int gap);
    for (int i = 0; i < 6; i++) begin
      drive(1'b1, i == 0, a[47-8*i -: 8]);
      if (gap > 0 && i < 5) idle(gap);
    end
  endtask

  function automatic logic [5:0] idx_of(input logic [47:0] a);
    logic [7:0] b [6];
    for (int i = 0; i < 6; i++) b[i] = a[47-8*i -: 8];
    return ref_crc(b)[31:26];
  endfunction

  localparam logic [47:0] STN   = 48'h02_11_22_33_44_55;
  localparam logic [47:0] OTHER = 48'h02_11_22_33_44_56;
  localparam logic [47:0] BCAST = 48'hFF_FF_FF_FF_FF_FF;
  localparam logic [47:0] MC1   = 48'h01_00_5E_00_00_01;
  localparam logic [47:0] MC2   = 48'h33_33_00_00_00_FB;

  initial begin
    logic [5:0] ix;
    // R1: reset state, decisions quiet; a frame equal to all zeros matches reset station
    cur_req = "R1";
    repeat (4) @(negedge clk);
    rst = 1'b0;
    idle(2);
    send(48'h0, 0); idle(2);
    // R2 / R10: program station, exact match accepted
    cur_req = "R2";
    wr(3'd0, 32'h22334455); wr(3'd1, 32'h00000211);
    send(STN, 0); idle(2);
    send(STN, 2); idle(2);
    // R3: unicast mismatch rejected
    cur_req = "R3";
    send(OTHER, 0); idle(1);
    send(48'h00_11_22_33_44_55, 1); idle(1);
    // R4: broadcast under both settings
    cur_req = "R4";
    send(BCAST, 0); idle(1);
    wr(3'd4, 32'h2);
    send(BCAST, 0); idle(1);
    // R5: promiscuous accepts everything
    cur_req = "R5";
    wr(3'd4, 32'h3);
    send(OTHER, 0); send(BCAST, 0); send(MC1, 0); idle(1);
    wr(3'd4, 32'h0);
    // R6: hash lookup, correct word vs the other word
    cur_req = "R6";
    ix = idx_of(MC1);
    if (ix[5]) wr(3'd3, 32'h1 << ix[4:0]); else wr(3'd2, 32'h1 << ix[4:0]);
    send(MC1, 0); idle(1);
    send(MC2, 0); idle(1);
    if (ix[5]) begin wr(3'd3, 32'h0); wr(3'd2, 32'h1 << ix[4:0]); end
    else       begin wr(3'd2, 32'h0); wr(3'd3, 32'h1 << ix[4:0]); end
    send(MC1, 0); idle(1);
    // R7: all ones and all zeros
    cur_req = "R7";
    wr(3'd2, 32'hFFFFFFFF); wr(3'd3, 32'hFFFFFFFF);
    send(MC1, 0); send(MC2, 1); send(48'h01_80_C2_00_00_0E, 0); idle(1);
    wr(3'd2, 32'h0); wr(3'd3, 32'h0);
    send(MC1, 0); send(MC2, 0); idle(1);
    // R8: back-to-back frames and uneven gaps
    cur_req = "R8";
    send(STN, 0); send(OTHER, 0); send(STN, 3); idle(3);
    // R9: restart mid-frame, stray octets ignored
    cur_req = "R9";
    drive(1'b1, 1'b1, 8'h02); drive(1'b1, 1'b0, 8'h11); drive(1'b1, 1'b0, 8'h22);
    send(STN, 0);
    for (int i = 0; i < 8; i++) drive(1'b1, 1'b0, 8'hFF);
    idle(2);
    drive(1'b1, 1'b1, 8'h02); drive(1'b1, 1'b1, 8'h02);
    for (int i = 1; i < 6; i++) drive(1'b1, 1'b0, STN[47-8*i -: 8]);
    idle(2);
    // R10: write in the same cycle as the sixth octet uses old settings
    cur_req = "R10";
    for (int i = 0; i < 5; i++) drive(1'b1, i == 0, OTHER[47-8*i -: 8]);
    @(negedge clk);
    octet_vld = 1'b1; octet_sof = 1'b0; octet = OTHER[7:0];
    wr_en = 1'b1; wr_sel = 3'd4; wr_data = 32'h1;
    idle(1);
    send(OTHER, 0); idle(1);
    wr(3'd4, 32'h0);
    send(OTHER, 0); idle(3);
    // R1: reset mid-frame clears settings and the open frame
    cur_req = "R1";
    drive(1'b1, 1'b1, 8'h02); drive(1'b1, 1'b0, 8'h11);
    @(negedge clk); rst = 1'b1; octet_vld = 1'b0;
    @(negedge clk); rst = 1'b0;
    for (int i = 0; i < 4; i++) drive(1'b1, 1'b0, 8'h33);
    idle(1);
    send(STN, 0); send(48'h0, 0); idle(3);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_bad++;
      $display("FAIL watchdog %s: actual=timeout expected=completion", cur_req);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule